// File: doc/BRIEF.md
# Load-Port Carrier Handoff Controller

This block is the equipment side of a ten-wire parallel handshake between an overhead transport robot and a single load port. The transport drives a two-bit port address, a valid strobe, a transfer request, a busy flag and a completion flag. The controller follows the exchange through a fixed sequence of states. It answers with a load request, an unload request and a ready level. A separate emergency-stop line can halt it from any point.

Each of the three timed phases of the exchange has its own watchdog. These are waiting for the equipment to accept, waiting for the robot to start moving, and the motion itself. Each watchdog counts ticks of a shared prescaler. A phase that overruns its limit sends the controller to a fault state and records a code that names the phase. Fault and emergency-stop states are left only through an explicit clear pulse, given while the transport lines are all quiet. Inputs are expected to be already synchronised to `clk`.

Top module: `lp_handoff_ctrl`

## Requirements
- R1: After reset the state is Idle (0), the fault code is None (0), and load request, unload request and ready are all low.
- R2: The controller is addressed only when `sel_i` equals `PORT_ID`. Idle (0) moves to Selected (1) while addressed. Selected returns to Idle when the address stops matching, and an unaddressed Idle stays Idle.
- R3: The state codes are Idle=0, Selected=1, ValidSeen=2, LoadReady=3, UnloadReady=4, Moving=5, Done=6, Stopped=7, Fault=8. Selected moves to ValidSeen on the first clock with `valid_i` high.
- R4: In ValidSeen, `accept_i` high picks the direction. With `carrier_present_i` low the state goes to LoadReady and `load_req_o` rises. With it high the state goes to UnloadReady and `unload_req_o` rises.
- R5: LoadReady or UnloadReady moves to Moving when `tr_req_i` and `busy_i` are both high. The request chosen in R4 stays high through Moving. `ready_o` is high exactly in LoadReady, UnloadReady and Moving. Load and unload requests are never high together.
- R6: Moving goes to Done when `busy_i` is low and `compt_i` is high. All three outputs are low in Done. Done returns to Idle once `valid_i` and `compt_i` are both low.
- R7: If ValidSeen lasts for `ACK_LIMIT` ticks, the controller enters Fault with code 1.
- R8: If LoadReady or UnloadReady lasts for `START_LIMIT` ticks, the controller enters Fault with code 2.
- R9: If Moving lasts for `MOVE_LIMIT` ticks, the controller enters Fault with code 3.
- R10: A tick occurs on every `TICK_DIV`-th clock after reset. A phase counts only the ticks seen while its states are held, starting from zero on entry. The Fault transition happens on the edge of the limit-th tick. When an expiry and a handshake transition fall in the same cycle, the expiry wins.
- R11: `estop_i` high sends the controller to Stopped (7) on the next edge from any state. All outputs are low there, and the fault code is kept.
- R12: Fault and Stopped are left only when `clear_i` is high while `sel_i` is 0 and valid, transfer request, busy, completion and emergency stop are all low. The controller then returns to Idle with code None. A clear given at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Port address from the transport |
| valid_i | input | 1 | Transport valid strobe |
| tr_req_i | input | 1 | Transport transfer request |
| busy_i | input | 1 | Transport motion in progress |
| compt_i | input | 1 | Transport motion finished |
| estop_i | input | 1 | Emergency stop, from either side |
| carrier_present_i | input | 1 | Carrier sensed on the port |
| accept_i | input | 1 | Equipment agrees to the handoff |
| clear_i | input | 1 | Leave Fault or Stopped |
| load_req_o | output | 1 | Port ready to receive a carrier |
| unload_req_o | output | 1 | Port ready to release a carrier |
| ready_o | output | 1 | Equipment interlocks satisfied |
| state_o | output | 4 | Current state code |
| fault_o | output | 2 | Latched fault code |

## Verification
The bench builds the controller with `PORT_ID`=2 and `TICK_DIV`=4. It sets the phase limits to 3, 4 and 6 ticks. With these values every watchdog expires within a few dozen clocks, so all three fault codes can be reached, along with their exact expiry edges and the tick phase relative to reset. The defaults would need seconds of simulated time. A port address other than zero lets the bench tell apart an unaddressed idle transport from a matching one.

// File: rtl/lp_handoff_pkg.sv
package lp_handoff_pkg;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_SELECTED   = 4'd1,
    ST_VALID      = 4'd2,
    ST_LOAD_RDY   = 4'd3,
    ST_UNLOAD_RDY = 4'd4,
    ST_MOVING     = 4'd5,
    ST_DONE       = 4'd6,
    ST_STOPPED    = 4'd7,
    ST_FAULT      = 4'd8
  } hs_state_e;

  typedef enum logic [1:0] {
    FLT_NONE          = 2'd0,
    FLT_ACK_TIMEOUT   = 2'd1,
    FLT_START_TIMEOUT = 2'd2,
    FLT_MOVE_TIMEOUT  = 2'd3
  } hs_fault_e;

  localparam int NUM_PHASES = 3;

  // Phase index 0: awaiting acceptance, 1: awaiting motion, 2: motion.
  function automatic logic [NUM_PHASES-1:0] phase_mask(input hs_state_e st);
    logic [NUM_PHASES-1:0] m;
    m    = '0;
    m[0] = (st == ST_VALID);
    m[1] = (st == ST_LOAD_RDY) || (st == ST_UNLOAD_RDY);
    m[2] = (st == ST_MOVING);
    return m;
  endfunction

  function automatic hs_fault_e fault_for(input logic [NUM_PHASES-1:0] expired);
    if (expired[0]) return FLT_ACK_TIMEOUT;
    if (expired[1]) return FLT_START_TIMEOUT;
    if (expired[2]) return FLT_MOVE_TIMEOUT;
    return FLT_NONE;
  endfunction

  function automatic logic is_ready_state(input hs_state_e st);
    return (st == ST_LOAD_RDY) || (st == ST_UNLOAD_RDY) || (st == ST_MOVING);
  endfunction

endpackage

// File: rtl/lp_tick_gen.sv
module lp_tick_gen #(
  parameter int TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = rst_n;
    end else begin : g_div
      logic [PW-1:0] div_q;
      assign tick_o = (div_q == PW'(TICK_DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end

      a_r10_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/lp_phase_watchdog.sv
module lp_phase_watchdog #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic tick_i,
  output logic arm_o,
  output logic cancel_o,
  output logic expire_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;

  logic [CW-1:0] cnt_q;
  logic          active_q;

  assign arm_o    = active_i & ~active_q;
  assign cancel_o = ~active_i & active_q;
  assign expire_o = active_i & tick_i & (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= active_i;
      if (!active_i)                cnt_q <= '0;
      else if (tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r10_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    active_i |-> (cnt_q < CW'(LIMIT)));
  a_r10_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/lp_handoff_fsm.sv
module lp_handoff_fsm
  import lp_handoff_pkg::*;
#(
  parameter int PORT_ID = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            sel_i,
  input  logic                  valid_i,
  input  logic                  tr_req_i,
  input  logic                  busy_i,
  input  logic                  compt_i,
  input  logic                  estop_i,
  input  logic                  carrier_present_i,
  input  logic                  accept_i,
  input  logic                  clear_i,
  input  logic [NUM_PHASES-1:0] expire_i,
  output logic [NUM_PHASES-1:0] phase_active_o,
  output hs_state_e             state_o,
  output hs_fault_e             fault_o,
  output logic                  load_req_o,
  output logic                  unload_req_o,
  output logic                  ready_o
);
  hs_state_e state_q, state_d;
  hs_fault_e fault_q, fault_d;
  logic      unload_dir_q, unload_dir_d;
  logic      addressed, lines_quiet, clear_ok, any_expire;

  assign addressed   = (sel_i == 2'(PORT_ID));
  assign lines_quiet = (sel_i == 2'b00) & ~valid_i & ~tr_req_i & ~busy_i & ~compt_i & ~estop_i;
  assign clear_ok    = clear_i & lines_quiet;
  assign any_expire  = |expire_i;

  always_comb begin
    state_d      = state_q;
    fault_d      = fault_q;
    unload_dir_d = unload_dir_q;
    if (estop_i) begin
      state_d = ST_STOPPED;
    end else begin
      case (state_q)
        ST_IDLE:     if (addressed) state_d = ST_SELECTED;
        ST_SELECTED: begin
          if (!addressed)   state_d = ST_IDLE;
          else if (valid_i) state_d = ST_VALID;
        end
        ST_VALID, ST_LOAD_RDY, ST_UNLOAD_RDY, ST_MOVING: begin
          if (any_expire) begin
            state_d = ST_FAULT;
            fault_d = fault_for(expire_i);
          end else if (state_q == ST_VALID) begin
            if (accept_i) begin
              unload_dir_d = carrier_present_i;
              state_d      = carrier_present_i ? ST_UNLOAD_RDY : ST_LOAD_RDY;
            end
          end else if (state_q == ST_MOVING) begin
            if (!busy_i && compt_i) state_d = ST_DONE;
          end else if (tr_req_i && busy_i) begin
            state_d = ST_MOVING;
          end
        end
        ST_DONE:     if (!valid_i && !compt_i) state_d = ST_IDLE;
        ST_STOPPED, ST_FAULT: begin
          if (clear_ok) begin
            state_d = ST_IDLE;
            fault_d = FLT_NONE;
          end
        end
        default:     state_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      fault_q      <= FLT_NONE;
      unload_dir_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      fault_q      <= fault_d;
      unload_dir_q <= unload_dir_d;
    end
  end

  assign phase_active_o = phase_mask(state_q);
  assign state_o        = state_q;
  assign fault_o        = fault_q;
  assign ready_o        = is_ready_state(state_q);
  assign load_req_o     = (state_q == ST_LOAD_RDY)   || ((state_q == ST_MOVING) && !unload_dir_q);
  assign unload_req_o   = (state_q == ST_UNLOAD_RDY) || ((state_q == ST_MOVING) &&  unload_dir_q);

  a_r11_estop_forces_stop: assert property (@(posedge clk) disable iff (!rst_n)
    estop_i |=> (state_q == ST_STOPPED));
  a_r11_estop_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (estop_i && state_q == ST_FAULT) |=> $stable(fault_q));
  a_r5_requests_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_req_o && unload_req_o));
  a_r2_unaddressed_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !addressed && !estop_i) |=> (state_q == ST_IDLE));
  a_r7_ack_expiry_code: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i[0] && !estop_i) |=> (state_q == ST_FAULT && fault_q == FLT_ACK_TIMEOUT));
  a_r8_start_expiry_code: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i[1] && !estop_i) |=> (state_q == ST_FAULT && fault_q == FLT_START_TIMEOUT));
  a_r9_move_expiry_code: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i[2] && !estop_i) |=> (state_q == ST_FAULT && fault_q == FLT_MOVE_TIMEOUT));
  a_r12_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && !clear_i && !estop_i) |=> (state_q == ST_FAULT && $stable(fault_q)));
  a_r12_fault_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT) |-> (fault_q != FLT_NONE));
  a_r6_done_after_compt: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MOVING && !estop_i && !any_expire && !busy_i && compt_i) |=> (state_q == ST_DONE));
endmodule

// File: rtl/lp_handoff_ctrl.sv
module lp_handoff_ctrl
  import lp_handoff_pkg::*;
#(
  parameter int PORT_ID     = 0,
  parameter int TICK_DIV    = 100000,
  parameter int ACK_LIMIT   = 2000,
  parameter int START_LIMIT = 2000,
  parameter int MOVE_LIMIT  = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       valid_i,
  input  logic       tr_req_i,
  input  logic       busy_i,
  input  logic       compt_i,
  input  logic       estop_i,
  input  logic       carrier_present_i,
  input  logic       accept_i,
  input  logic       clear_i,
  output logic       load_req_o,
  output logic       unload_req_o,
  output logic       ready_o,
  output logic [3:0] state_o,
  output logic [1:0] fault_o
);
  logic                  tick;
  logic [NUM_PHASES-1:0] phase_active, expire, arm, cancel;
  hs_state_e             state;
  hs_fault_e             fault;

  lp_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  for (genvar gi = 0; gi < NUM_PHASES; gi++) begin : g_wd
    localparam int LIM = (gi == 0) ? ACK_LIMIT : (gi == 1) ? START_LIMIT : MOVE_LIMIT;
    lp_phase_watchdog #(.LIMIT(LIM)) u_wd (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (phase_active[gi]),
      .tick_i   (tick),
      .arm_o    (arm[gi]),
      .cancel_o (cancel[gi]),
      .expire_o (expire[gi])
    );
  end

  lp_handoff_fsm #(.PORT_ID(PORT_ID)) u_fsm (
    .clk               (clk),
    .rst_n             (rst_n),
    .sel_i             (sel_i),
    .valid_i           (valid_i),
    .tr_req_i          (tr_req_i),
    .busy_i            (busy_i),
    .compt_i           (compt_i),
    .estop_i           (estop_i),
    .carrier_present_i (carrier_present_i),
    .accept_i          (accept_i),
    .clear_i           (clear_i),
    .expire_i          (expire),
    .phase_active_o    (phase_active),
    .state_o           (state),
    .fault_o           (fault),
    .load_req_o        (load_req_o),
    .unload_req_o      (unload_req_o),
    .ready_o           (ready_o)
  );

  assign state_o = state;
  assign fault_o = fault;

  a_r10_one_phase_active: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_active));
  a_r10_one_arm_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arm));
  a_r10_cancel_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    |cancel |-> (phase_active != $past(phase_active)));
endmodule

// File: tb/lp_handoff_ctrl_tb.sv
module lp_handoff_ctrl_tb;
  localparam int PORT = 2;
  localparam int DIV  = 4;
  localparam int L1   = 3;
  localparam int L2   = 4;
  localparam int L3   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic valid = 0, tr_req = 0, busy = 0, compt = 0, estop = 0;
  logic carrier = 0, accept = 0, clear = 0;
  logic load_req, unload_req, ready;
  logic [3:0] state;
  logic [1:0] fault;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lp_handoff_ctrl #(.PORT_ID(PORT), .TICK_DIV(DIV), .ACK_LIMIT(L1),
                    .START_LIMIT(L2), .MOVE_LIMIT(L3)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .valid_i(valid), .tr_req_i(tr_req),
    .busy_i(busy), .compt_i(compt), .estop_i(estop), .carrier_present_i(carrier),
    .accept_i(accept), .clear_i(clear), .load_req_o(load_req),
    .unload_req_o(unload_req), .ready_o(ready), .state_o(state), .fault_o(fault));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: integer state, tick phase and per-phase elapsed ticks.
  int m_st = 0, m_fault = 0, m_div = 0, m_el = 0;
  bit m_unload = 0;

  function automatic int lim_of(input int st);
    if (st == 2) return L1;
    if (st == 3 || st == 4) return L2;
    if (st == 5) return L3;
    return 0;
  endfunction

  function automatic int phase_of(input int st);
    if (st == 2) return 1;
    if (st == 3 || st == 4) return 2;
    if (st == 5) return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_fault = 0; m_div = 0; m_el = 0; m_unload = 0;
    end else begin
      bit tk, exp_now;
      int nx, ph_old;
      tk = (m_div == DIV - 1);
      m_div = tk ? 0 : m_div + 1;
      ph_old = phase_of(m_st);
      exp_now = (ph_old != 0) && tk && (m_el + 1 == lim_of(m_st));
      nx = m_st;
      if (estop) nx = 7;
      else if (exp_now) begin nx = 8; m_fault = ph_old; end
      else case (m_st)
        0: if (sel == PORT) nx = 1;
        1: if (sel != PORT) nx = 0; else if (valid) nx = 2;
        2: if (accept) begin m_unload = carrier; nx = carrier ? 4 : 3; end
        3, 4: if (tr_req && busy) nx = 5;
        5: if (!busy && compt) nx = 6;
        6: if (!valid && !compt) nx = 0;
        default: if (clear && sel == 0 && !valid && !tr_req && !busy && !compt) begin
          nx = 0; m_fault = 0;
        end
      endcase
      if (ph_old != 0 && phase_of(nx) == ph_old) m_el = m_el + (tk ? 1 : 0);
      else m_el = 0;
      m_st = nx;
    end
  end

  function automatic string tag_of(input int st);
    case (st)
      0, 1: return "R2";
      2: return "R7/R10";
      3, 4: return "R8/R10";
      5: return "R9/R10";
      6: return "R6";
      7: return "R11";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      int e_l, e_u, e_r;
      e_r = (m_st >= 3 && m_st <= 5);
      e_l = (m_st == 3) || (m_st == 5 && !m_unload);
      e_u = (m_st == 4) || (m_st == 5 && m_unload);
      chk({tag_of(m_st), " state"}, state, m_st);
      chk({tag_of(m_st), " fault"}, fault, m_fault);
      chk("R5 load_req", load_req, e_l);
      chk("R5 unload_req", unload_req, e_u);
      chk("R5 ready", ready, e_r);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drop_all();
    sel = 0; valid = 0; tr_req = 0; busy = 0; compt = 0; estop = 0; accept = 0;
  endtask

  task automatic pulse_clear();
    clear = 1; step(1); clear = 0; step(1);
  endtask

  task automatic to_valid();
    sel = PORT; step(1); valid = 1; step(1);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 state", state, 0); chk("R1 fault", fault, 0);
    chk("R1 outputs", {load_req, unload_req, ready}, 0);

    sel = 1; step(5); chk("R2 wrong address stays idle", state, 0);
    sel = 3; step(3); chk("R2 wrong address 3", state, 0);

    // load path
    sel = PORT; step(1); chk("R2 selected", state, 1);
    valid = 1; step(1); chk("R3 valid seen", state, 2);
    accept = 1; step(1); accept = 0;
    chk("R4 load ready", state, 3); chk("R4 load_req", load_req, 1);
    chk("R5 ready in load", ready, 1);
    tr_req = 1; busy = 1; step(1);
    chk("R5 moving", state, 5); chk("R5 load_req kept", load_req, 1);
    busy = 0; compt = 1; step(1);
    chk("R6 done", state, 6); chk("R6 outputs low", {load_req, unload_req, ready}, 0);
    valid = 0; compt = 0; tr_req = 0; step(1);
    chk("R6 back to idle", state, 0);
    sel = 0; step(2);

    // unload path
    carrier = 1; to_valid(); accept = 1; step(1); accept = 0;
    chk("R4 unload ready", state, 4); chk("R4 unload_req", unload_req, 1);
    chk("R5 no load_req", load_req, 0);
    tr_req = 1; busy = 1; step(1); chk("R5 unload moving", unload_req, 1);
    busy = 0; compt = 1; step(1); chk("R6 unload done", state, 6);
    drop_all(); compt = 0; tr_req = 0; step(2); carrier = 0;

    // TA1 expiry
    to_valid(); step(L1 * DIV + 2);
    chk("R7 fault state", state, 8); chk("R7 code", fault, 1);
    pulse_clear(); chk("R12 clear ignored while lines busy", state, 8);
    drop_all(); step(3); chk("R12 fault held without clear", state, 8);
    pulse_clear(); chk("R12 cleared to idle", state, 0); chk("R12 code none", fault, 0);

    // TA2 expiry
    to_valid(); accept = 1; step(1); accept = 0; step(L2 * DIV + 2);
    chk("R8 code", fault, 2);
    estop = 1; step(1); estop = 0;
    chk("R11 stop from fault", state, 7); chk("R11 code kept", fault, 2);
    drop_all(); pulse_clear(); chk("R12 cleared from stop", state, 0);

    // TA3 expiry
    to_valid(); accept = 1; step(1); accept = 0; tr_req = 1; busy = 1;
    step(L3 * DIV + 2); chk("R9 code", fault, 3);
    drop_all(); pulse_clear();

    // emergency stop mid-motion
    to_valid(); accept = 1; step(1); accept = 0; tr_req = 1; busy = 1; step(1);
    estop = 1; step(1);
    chk("R11 stopped", state, 7); chk("R11 outputs low", {load_req, unload_req, ready}, 0);
    estop = 0; step(2); chk("R11 stays stopped", state, 7);
    drop_all(); pulse_clear(); step(2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule